// File: doc/BRIEF.md
# Passive Serial Configuration Master

This block loads a configuration bitstream into a programmable target device over a passive serial link. When software or a boot sequencer pulses `start_i` with a byte count, the block first pulls the active-low configuration request line low for a programmed number of system clock cycles. It then checks that the device has answered by pulling its active-low status line low, releases the request, waits a short settling time, and polls until the device lets its status line go high again.

Once the device is ready, the block takes bytes from a valid/ready stream. It shifts each byte out least-significant bit first on a data line, with a clock that it generates itself. Every bit has three phases: the clock goes low, the data bit is driven, and the clock rises. The device samples the data on the rising edge. Each phase lasts a programmable number of system clock cycles. When all bytes have been sent, the block checks the device's configuration-done input and sends a fixed train of extra clock pulses. It then reports success.

Every failure ends the sequence with a one-cycle fail pulse and an error code, and leaves the link lines at their idle levels. The failures are: no answer to the request, a timeout while waiting for the status release, done still low after the data, or an external cancel.

Top module: `pscfg_master`

## Requirements
- R1: After reset, and whenever the block is idle, `cfg_req_n_o` is 1, `dclk_o` is 0, `ddata_o` is 0 after reset, `busy_o` is 0, `in_ready_o` is 0, `ok_o` and `fail_o` are 0, and `err_code_o` is 0.
- R2: A `start_i` pulse while idle drives `cfg_req_n_o` low for exactly PULSE_CYC system clock cycles.
- R3: If `status_n_i` is not low in the last cycle of the request pulse, the block fails with error code 1 and produces no `dclk_o` edge. The fail pulse comes PULSE_CYC+1 rising clock edges after the edge that sampled `start_i`, counting that edge as the first.
- R4: After the request is released, the block waits SETTLE_CYC cycles and then polls `status_n_i` for high for at most TIMEOUT_CYC cycles. If the status never goes high, it fails with error code 2, exactly PULSE_CYC+SETTLE_CYC+TIMEOUT_CYC+1 edges after the edge that sampled `start_i`.
- R5: The bytes are sent in the order they were accepted, least-significant bit first, with exactly one rising `dclk_o` edge per bit. `ddata_o` does not change in the cycle in which `dclk_o` rises.
- R6: Every high phase of `dclk_o`, both during data and during the trailing pulses, lasts exactly PHASE_DIV system clock cycles.
- R7: `in_ready_o` is high only during the data phase, when the shifter is empty and fewer than the requested number of bytes have been accepted. While no valid byte is offered, `dclk_o` stays low and produces no edge.
- R8: If `conf_done_i` is low once the last byte has been sent, the block fails with error code 3 and sends no trailing pulses.
- R9: When done is high, the block sends exactly TAIL_CLKS (12 by default) extra `dclk_o` pulses, each high then low, and then raises `ok_o` for one cycle.
- R10: `abort_i` while busy ends the sequence. In the next cycle `fail_o` is 1 with error code 4, `cfg_req_n_o` is 1, `dclk_o` is 0 and `busy_o` is 0.
- R11: `ok_o` and `fail_o` are single-cycle pulses and are never high together. Exactly one of them ends each started sequence.
- R12: A byte count of 0 skips the data phase: `in_ready_o` never rises, and the block goes straight to the done check and the trailing pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a load when the block is idle |
| byte_count_i | input | CNT_W | Number of bytes to send, sampled with start |
| in_data_i | input | 8 | Bitstream byte |
| in_valid_i | input | 1 | Byte stream valid |
| in_ready_o | output | 1 | Byte stream ready |
| abort_i | input | 1 | Cancels the sequence in progress |
| status_n_i | input | 1 | Device status, active low |
| conf_done_i | input | 1 | Device configuration done |
| cfg_req_n_o | output | 1 | Configuration request to the device, active low |
| dclk_o | output | 1 | Serial clock; the device samples on the rising edge |
| ddata_o | output | 1 | Serial data |
| busy_o | output | 1 | A sequence is in progress |
| ok_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |
| err_code_o | output | 3 | Failure cause, valid with fail_o: 1 no answer, 2 timeout, 3 done low, 4 cancelled; 0 otherwise |

## Verification
The hardest state to reach from the ports is a stall in the middle of the data phase. The shifter must be empty while bytes are still owed and nothing is being offered, and the serial clock must sit still there. The bench gets there by offering one byte of a two-byte load and then holding valid low for longer than eight bit times, which it counts in `dclk_o` edges. A behavioural model of the target device responds to the request line and releases its status line after a set delay. Switching off the model's answer, its release or its done level produces each failure path, with the exact fail latencies counted in clock edges.

// File: rtl/pscfg_pkg.sv
package pscfg_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PULSE,
      ST_SETTLE,
      ST_POLL,
      ST_LOAD,
      ST_CHECK,
      ST_TAIL
   } cfg_state_e;

   typedef enum logic [2:0] {
      ERR_NONE    = 3'd0,
      ERR_NOACK   = 3'd1,
      ERR_TIMEOUT = 3'd2,
      ERR_NODONE  = 3'd3,
      ERR_ABORT   = 3'd4
   } cfg_err_e;

   typedef enum logic [1:0] {
      PH_LOW,
      PH_SETUP,
      PH_HIGH
   } bit_phase_e;

endpackage

// File: rtl/pscfg_timer.sv
module pscfg_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         expired_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/pscfg_shift.sv
module pscfg_shift
   import pscfg_pkg::*;
#(
   parameter int unsigned PHASE_DIV = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_i,
   input  logic       want_i,
   input  logic       flush_i,
   input  logic [7:0] in_data_i,
   input  logic       in_valid_i,
   output logic       in_ready_o,
   output logic       sclk_o,
   output logic       sdata_o,
   output logic       idle_o
);

   localparam int unsigned DW = (PHASE_DIV > 1) ? $clog2(PHASE_DIV) : 1;

   logic [7:0] sh_q;
   logic [3:0] left_q;
   bit_phase_e ph_q;
   logic       sclk_q;
   logic       sdata_q;
   logic       tick;
   logic       empty;
   logic       accept;
   logic       advance;

   assign empty      = (left_q == 4'd0);
   assign in_ready_o = run_i && want_i && empty;
   assign accept     = in_ready_o && in_valid_i;
   assign advance    = !empty && tick;

   generate
      if (PHASE_DIV == 1) begin : g_fast
         assign tick = 1'b1;
      end else begin : g_div
         logic [DW-1:0] dc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dc_q <= DW'(PHASE_DIV - 1);
            end else if (flush_i || accept || advance) begin
               dc_q <= DW'(PHASE_DIV - 1);
            end else if (dc_q != '0) begin
               dc_q <= dc_q - 1'b1;
            end
         end
         assign tick = (dc_q == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         left_q  <= '0;
         ph_q    <= PH_LOW;
         sclk_q  <= 1'b0;
         sdata_q <= 1'b0;
      end else if (flush_i) begin
         left_q  <= '0;
         ph_q    <= PH_LOW;
         sclk_q  <= 1'b0;
         sdata_q <= 1'b0;
      end else if (accept) begin
         sh_q   <= in_data_i;
         left_q <= 4'd8;
         ph_q   <= PH_LOW;
      end else if (advance) begin
         case (ph_q)
            PH_LOW: begin
               ph_q    <= PH_SETUP;
               sdata_q <= sh_q[0];
            end
            PH_SETUP: begin
               ph_q   <= PH_HIGH;
               sclk_q <= 1'b1;
            end
            default: begin
               sclk_q <= 1'b0;
               sh_q   <= {1'b0, sh_q[7:1]};
               left_q <= left_q - 1'b1;
               ph_q   <= PH_LOW;
            end
         endcase
      end
   end

   assign sclk_o  = sclk_q;
   assign sdata_o = sdata_q;
   assign idle_o  = empty;

   // R5: data is settled before the rising clock edge
   a_r5_data_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_q) |-> $stable(sdata_q));

   // R7: no clock activity once the shifter has run dry
   a_r7_no_clock_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !sclk_q);

endmodule

// File: rtl/pscfg_master.sv
module pscfg_master
   import pscfg_pkg::*;
#(
   parameter int unsigned PULSE_CYC   = 100,
   parameter int unsigned SETTLE_CYC  = 100,
   parameter int unsigned TIMEOUT_CYC = 5000000,
   parameter int unsigned PHASE_DIV   = 1,
   parameter int unsigned TAIL_CLKS   = 12,
   parameter int unsigned CNT_W       = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] byte_count_i,
   input  logic [7:0]       in_data_i,
   input  logic             in_valid_i,
   output logic             in_ready_o,
   input  logic             abort_i,
   input  logic             status_n_i,
   input  logic             conf_done_i,
   output logic             cfg_req_n_o,
   output logic             dclk_o,
   output logic             ddata_o,
   output logic             busy_o,
   output logic             ok_o,
   output logic             fail_o,
   output logic [2:0]       err_code_o
);

   localparam int unsigned M1   = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
   localparam int unsigned M2   = (M1 > TIMEOUT_CYC) ? M1 : TIMEOUT_CYC;
   localparam int unsigned TMAX = (M2 > PHASE_DIV) ? M2 : PHASE_DIV;
   localparam int unsigned TW   = $clog2(TMAX + 1);
   localparam int unsigned NW   = $clog2(TAIL_CLKS + 1);

   generate
      if (PULSE_CYC < 1)   begin : g_bad_pulse   $error("PULSE_CYC must be at least 1");   end
      if (SETTLE_CYC < 1)  begin : g_bad_settle  $error("SETTLE_CYC must be at least 1");  end
      if (TIMEOUT_CYC < 1) begin : g_bad_timeout $error("TIMEOUT_CYC must be at least 1"); end
      if (PHASE_DIV < 1)   begin : g_bad_div     $error("PHASE_DIV must be at least 1");   end
      if (TAIL_CLKS < 1)   begin : g_bad_tail    $error("TAIL_CLKS must be at least 1");   end
      if (CNT_W < 1)       begin : g_bad_cnt     $error("CNT_W must be at least 1");       end
   endgenerate

   cfg_state_e       state_q, st_nxt;
   cfg_err_e         err_q, err_nxt;
   logic [CNT_W-1:0] total_q, taken_q;
   logic [NW-1:0]    tail_n_q, tail_n_nxt;
   logic             tail_clk_q, tail_clk_nxt;
   logic             ok_q, ok_nxt, fail_q, fail_nxt;
   logic             tmr_load, tmr_exp;
   logic [TW-1:0]    tmr_val;
   logic             abort_hit, want, accept;
   logic             sh_sclk, sh_sdata, sh_idle;

   assign abort_hit = abort_i && (state_q != ST_IDLE);
   assign want      = (taken_q != total_q);
   assign accept    = in_ready_o && in_valid_i;

   pscfg_timer #(.W(TW)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (tmr_load),
      .val_i     (tmr_val),
      .expired_o (tmr_exp)
   );

   pscfg_shift #(.PHASE_DIV(PHASE_DIV)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (state_q == ST_LOAD),
      .want_i     (want),
      .flush_i    (abort_hit),
      .in_data_i  (in_data_i),
      .in_valid_i (in_valid_i),
      .in_ready_o (in_ready_o),
      .sclk_o     (sh_sclk),
      .sdata_o    (sh_sdata),
      .idle_o     (sh_idle)
   );

   always_comb begin
      st_nxt       = state_q;
      err_nxt      = ERR_NONE;
      ok_nxt       = 1'b0;
      fail_nxt     = 1'b0;
      tail_clk_nxt = tail_clk_q;
      tail_n_nxt   = tail_n_q;
      tmr_load     = 1'b0;
      tmr_val      = '0;
      if (abort_hit) begin
         st_nxt       = ST_IDLE;
         fail_nxt     = 1'b1;
         err_nxt      = ERR_ABORT;
         tail_clk_nxt = 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  st_nxt   = ST_PULSE;
                  tmr_load = 1'b1;
                  tmr_val  = TW'(PULSE_CYC - 1);
               end
            end
            ST_PULSE: begin
               if (tmr_exp) begin
                  if (!status_n_i) begin
                     st_nxt   = ST_SETTLE;
                     tmr_load = 1'b1;
                     tmr_val  = TW'(SETTLE_CYC - 1);
                  end else begin
                     st_nxt   = ST_IDLE;
                     fail_nxt = 1'b1;
                     err_nxt  = ERR_NOACK;
                  end
               end
            end
            ST_SETTLE: begin
               if (tmr_exp) begin
                  st_nxt   = ST_POLL;
                  tmr_load = 1'b1;
                  tmr_val  = TW'(TIMEOUT_CYC - 1);
               end
            end
            ST_POLL: begin
               if (status_n_i) begin
                  st_nxt = (total_q == '0) ? ST_CHECK : ST_LOAD;
               end else if (tmr_exp) begin
                  st_nxt   = ST_IDLE;
                  fail_nxt = 1'b1;
                  err_nxt  = ERR_TIMEOUT;
               end
            end
            ST_LOAD: begin
               if (!want && sh_idle) begin
                  st_nxt = ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (conf_done_i) begin
                  st_nxt       = ST_TAIL;
                  tail_clk_nxt = 1'b1;
                  tail_n_nxt   = '0;
                  tmr_load     = 1'b1;
                  tmr_val      = TW'(PHASE_DIV - 1);
               end else begin
                  st_nxt   = ST_IDLE;
                  fail_nxt = 1'b1;
                  err_nxt  = ERR_NODONE;
               end
            end
            ST_TAIL: begin
               if (tmr_exp) begin
                  if (tail_clk_q) begin
                     tail_clk_nxt = 1'b0;
                     tmr_load     = 1'b1;
                     tmr_val      = TW'(PHASE_DIV - 1);
                  end else if (tail_n_q == NW'(TAIL_CLKS - 1)) begin
                     st_nxt = ST_IDLE;
                     ok_nxt = 1'b1;
                  end else begin
                     tail_n_nxt   = tail_n_q + 1'b1;
                     tail_clk_nxt = 1'b1;
                     tmr_load     = 1'b1;
                     tmr_val      = TW'(PHASE_DIV - 1);
                  end
               end
            end
            default: st_nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         err_q      <= ERR_NONE;
         ok_q       <= 1'b0;
         fail_q     <= 1'b0;
         tail_clk_q <= 1'b0;
         tail_n_q   <= '0;
         total_q    <= '0;
         taken_q    <= '0;
      end else begin
         state_q    <= st_nxt;
         err_q      <= err_nxt;
         ok_q       <= ok_nxt;
         fail_q     <= fail_nxt;
         tail_clk_q <= tail_clk_nxt;
         tail_n_q   <= tail_n_nxt;
         if ((state_q == ST_IDLE) && start_i) begin
            total_q <= byte_count_i;
            taken_q <= '0;
         end else if (accept) begin
            taken_q <= taken_q + 1'b1;
         end
      end
   end

   assign cfg_req_n_o = (state_q != ST_PULSE);
   assign dclk_o      = sh_sclk | tail_clk_q;
   assign ddata_o     = sh_sdata;
   assign busy_o      = (state_q != ST_IDLE);
   assign ok_o        = ok_q;
   assign fail_o      = fail_q;
   assign err_code_o  = err_q;

   // R10: a cancel while busy returns the link to idle in one cycle
   a_r10_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && abort_i) |=>
         (fail_o && err_code_o == 3'd4 && cfg_req_n_o && !dclk_o && !busy_o));

   // R11: result pulses last one cycle and exclude each other
   a_r11_ok_single: assert property (@(posedge clk) disable iff (!rst_n)
      ok_o |=> !ok_o);
   a_r11_fail_single: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |=> !fail_o);
   a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(ok_o && fail_o));

   // R3: a no-answer failure follows a high status sample
   a_r3_noack_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_o && err_code_o == 3'd1) |-> $past(status_n_i));

   // R7: bytes move only during a sequence with the request released
   a_r7_accept_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready_o && in_valid_i) |-> (busy_o && cfg_req_n_o));

   // R9: success is reported with the serial clock back low
   a_r9_ok_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
      ok_o |-> !dclk_o);

endmodule

// File: tb/pscfg_master_bench.sv
module pscfg_master_bench;

   localparam int P   = 8;
   localparam int S   = 6;
   localparam int T   = 200;
   localparam int D   = 2;
   localparam int TL  = 12;
   localparam int CW  = 16;
   localparam int REL = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [CW-1:0] byte_count_i = '0;
   logic [7:0]    in_data_i = '0;
   logic          in_valid_i = 1'b0;
   logic          in_ready_o;
   logic          abort_i = 1'b0;
   logic          status_n_i = 1'b1;
   logic          conf_done_i;
   logic          cfg_req_n_o, dclk_o, ddata_o, busy_o, ok_o, fail_o;
   logic [2:0]    err_code_o;

   int checks = 0;
   int errors = 0;

   // device model knobs
   logic dev_ack = 1'b1;
   logic dev_release = 1'b1;
   logic dev_done = 1'b1;
   int   rel_cnt = 0;

   // monitor state
   logic prev_dclk = 1'b0;
   logic prev_req = 1'b1;
   int   rises = 0;
   int   high_run = 0;
   int   min_high = 1000;
   int   max_high = 0;
   int   req_run = 0;
   int   last_req_low = 0;
   int   ok_seen = 0;
   int   fail_seen = 0;
   int   ready_seen = 0;
   logic cap [0:255];
   logic [7:0] tx [0:7];

   always #10 clk = ~clk;

   assign conf_done_i = dev_done;

   pscfg_master #(
      .PULSE_CYC(P), .SETTLE_CYC(S), .TIMEOUT_CYC(T),
      .PHASE_DIV(D), .TAIL_CLKS(TL), .CNT_W(CW)
   ) u_pscfg_master (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_count_i(byte_count_i),
      .in_data_i(in_data_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
      .abort_i(abort_i), .status_n_i(status_n_i), .conf_done_i(conf_done_i),
      .cfg_req_n_o(cfg_req_n_o), .dclk_o(dclk_o), .ddata_o(ddata_o),
      .busy_o(busy_o), .ok_o(ok_o), .fail_o(fail_o), .err_code_o(err_code_o)
   );

   // target device model, updated away from the active edge
   always @(negedge clk) begin
      if (!rst_n) begin
         status_n_i = 1'b1;
         rel_cnt = 0;
      end else if (!cfg_req_n_o) begin
         status_n_i = dev_ack ? 1'b0 : 1'b1;
         rel_cnt = 0;
      end else if (!status_n_i && dev_release) begin
         rel_cnt++;
         if (rel_cnt >= REL) status_n_i = 1'b1;
      end
   end

   // link monitor
   always @(negedge clk) begin
      if (dclk_o && !prev_dclk) begin
         if (rises < 256) cap[rises] = ddata_o;
         rises++;
         high_run = 1;
      end else if (dclk_o) begin
         high_run++;
      end else if (prev_dclk) begin
         if (high_run < min_high) min_high = high_run;
         if (high_run > max_high) max_high = high_run;
      end
      if (!cfg_req_n_o) req_run++;
      else if (!prev_req) begin
         last_req_low = req_run;
         req_run = 0;
      end
      if (ok_o) ok_seen++;
      if (fail_o) fail_seen++;
      if (in_ready_o) ready_seen++;
      prev_dclk = dclk_o;
      prev_req = cfg_req_n_o;
   end

   task automatic chk(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clear_mon();
      @(posedge clk);
      rises = 0; high_run = 0; min_high = 1000; max_high = 0;
      req_run = 0; last_req_low = 0; ok_seen = 0; fail_seen = 0; ready_seen = 0;
   endtask

   task automatic do_start(input int count);
      @(negedge clk);
      start_i = 1'b1;
      byte_count_i = CW'(count);
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic feed(input int first, input int n);
      for (int k = first; k < first + n; k++) begin
         @(negedge clk);
         in_valid_i = 1'b1;
         in_data_i = tx[k];
         while (!in_ready_o) @(negedge clk);
         @(posedge clk);
      end
      @(negedge clk);
      in_valid_i = 1'b0;
   endtask

   task automatic wait_result(output logic got_ok, output int code);
      got_ok = 1'b0;
      code = -1;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (ok_o || fail_o) begin
            got_ok = ok_o;
            code = int'(err_code_o);
            break;
         end
      end
      @(posedge clk);
   endtask

   // start and count edges until fail, first counted edge samples start
   task automatic start_measure(input int count, output int n, output int code);
      @(negedge clk);
      start_i = 1'b1;
      byte_count_i = CW'(count);
      n = 0;
      code = -1;
      for (int i = 0; i < 5000; i++) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         start_i = 1'b0;
         if (fail_o || ok_o) begin
            code = int'(err_code_o);
            break;
         end
      end
      @(posedge clk);
   endtask

   function automatic int cap_byte(input int k);
      logic [7:0] b;
      for (int i = 0; i < 8; i++) b[i] = cap[8*k + i];
      return int'(b);
   endfunction

   task automatic t_reset();
      @(negedge clk);
      chk("R1", int'(cfg_req_n_o), 1, "request idle high");
      chk("R1", int'(dclk_o), 0, "clock idle low");
      chk("R1", int'(ddata_o), 0, "data low after reset");
      chk("R1", int'(busy_o | in_ready_o | ok_o | fail_o), 0, "busy/ready/ok/fail low");
      chk("R1", int'(err_code_o), 0, "error code zero");
   endtask

   task automatic t_normal();
      logic g; int c;
      dev_ack = 1; dev_release = 1; dev_done = 1;
      tx[0] = 8'hA5; tx[1] = 8'h3C; tx[2] = 8'h81;
      clear_mon();
      do_start(3);
      feed(0, 3);
      wait_result(g, c);
      chk("R9", int'(g), 1, "normal load ends in success");
      chk("R11", ok_seen, 1, "ok pulse cycles");
      chk("R11", fail_seen, 0, "no fail pulse on success");
      chk("R2", last_req_low, P, "request low cycles");
      chk("R9", rises, 3*8 + TL, "data plus trailing rising edges");
      for (int k = 0; k < 3; k++) chk("R5", cap_byte(k), int'(tx[k]), "byte sent LSB first");
      chk("R6", min_high, D, "shortest clock high phase");
      chk("R6", max_high, D, "longest clock high phase");
      chk("R1", int'(busy_o | dclk_o), 0, "idle again after success");
   endtask

   task automatic t_stall();
      logic g; int c; int r1;
      dev_ack = 1; dev_release = 1; dev_done = 1;
      tx[0] = 8'h5A; tx[1] = 8'hF0;
      clear_mon();
      do_start(2);
      feed(0, 1);
      repeat (70) @(negedge clk);
      @(posedge clk);
      r1 = rises;
      chk("R7", r1, 8, "edges after first byte before stall");
      @(negedge clk);
      chk("R7", int'(in_ready_o), 1, "ready while empty and bytes owed");
      chk("R7", int'(dclk_o), 0, "clock low while stalled");
      repeat (10) @(negedge clk);
      @(posedge clk);
      chk("R7", rises, r1, "no edges while stream empty");
      feed(1, 1);
      wait_result(g, c);
      chk("R9", int'(g), 1, "stalled load still succeeds");
      chk("R5", cap_byte(0), 8'h5A, "first byte after stall");
      chk("R5", cap_byte(1), 8'hF0, "second byte after stall");
   endtask

   task automatic t_noack();
      int n, c;
      dev_ack = 0; dev_release = 1; dev_done = 1;
      clear_mon();
      start_measure(2, n, c);
      chk("R3", c, 1, "no-answer error code");
      chk("R3", n, P + 1, "no-answer fail latency");
      chk("R3", rises, 0, "no clock edges on no-answer");
      chk("R3", ready_seen, 0, "no ready on no-answer");
   endtask

   task automatic t_timeout();
      int n, c;
      dev_ack = 1; dev_release = 0; dev_done = 1;
      clear_mon();
      start_measure(2, n, c);
      chk("R4", c, 2, "timeout error code");
      chk("R4", n, P + S + T + 1, "timeout fail latency");
      chk("R4", rises, 0, "no clock edges on timeout");
      dev_release = 1;
   endtask

   task automatic t_nodone();
      logic g; int c;
      dev_ack = 1; dev_release = 1; dev_done = 0;
      tx[0] = 8'hC3;
      clear_mon();
      do_start(1);
      feed(0, 1);
      wait_result(g, c);
      chk("R8", c, 3, "done-low error code");
      chk("R8", rises, 8, "no trailing pulses when done low");
      chk("R11", ok_seen, 0, "no ok on boot failure");
      dev_done = 1;
   endtask

   task automatic t_abort();
      int r1;
      dev_ack = 1; dev_release = 1; dev_done = 1;
      tx[0] = 8'hFF;
      clear_mon();
      do_start(3);
      feed(0, 1);
      repeat (20) @(negedge clk);
      abort_i = 1'b1;
      @(negedge clk);
      abort_i = 1'b0;
      chk("R10", int'(fail_o), 1, "fail pulse after cancel");
      chk("R10", int'(err_code_o), 4, "cancel error code");
      chk("R10", int'(cfg_req_n_o) * 2 + int'(dclk_o), 2, "request high, clock low after cancel");
      chk("R10", int'(busy_o | in_ready_o), 0, "not busy after cancel");
      @(posedge clk);
      r1 = rises;
      repeat (20) @(negedge clk);
      @(posedge clk);
      chk("R10", rises, r1, "no edges after cancel");
   endtask

   task automatic t_zero();
      logic g; int c;
      dev_ack = 1; dev_release = 1; dev_done = 1;
      clear_mon();
      do_start(0);
      wait_result(g, c);
      chk("R12", int'(g), 1, "zero count succeeds");
      chk("R12", rises, TL, "only trailing pulses on zero count");
      chk("R12", ready_seen, 0, "ready never raised on zero count");
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_normal();
      t_stall();
      t_noack();
      t_timeout();
      t_nodone();
      t_abort();
      t_zero();
      repeat (5) @(negedge clk);
      summary();
      $finish;
   end

endmodule